// File: doc/BRIEF.md
# Interlocked Word Transfer Between Unrelated Clocks

This block moves one multi-bit word at a time from a sending clock domain to a receiving clock domain whose clocks have no known relation. The sender offers a word with `tx_valid` while `tx_ready` is high. The block copies the word into a holding register and keeps that register frozen for the whole exchange. The data bits are never synchronized one by one. Only a single request line and a single acknowledge line cross between the domains, and each of them passes through a flip-flop chain clocked by the domain that receives it.

The exchange is a full four-phase handshake, so it never relies on timing. The request rises and then waits for the acknowledge to be seen high. The request then falls and waits for the acknowledge to be seen low. Only after that does the sender report ready again. No clock ratio is assumed and no fixed hold count is used. The receiver captures the held word when it sees the request. It shows the word on `rx_data` together with a one-cycle `rx_valid` pulse, and it keeps the acknowledge up until the request has gone away.

Each domain has its own active-high reset. A reset takes effect at once. Its release is retimed to the local clock through a flip-flop chain.

Top module: `hs_bundle_xfer`

## Requirements
- R1: While a reset is applied, `tx_ready` and `rx_valid` are 0 and `rx_data` is all zeros. Within six sending clocks after both resets are released, `tx_ready` is 1.
- R2: A word is taken only on a sending clock edge where `tx_valid` and `tx_ready` are both 1. While `tx_ready` is 0, `tx_valid` and `tx_data` have no effect, and a word offered then is never delivered.
- R3: The holding register does not change from the cycle the request rises until the sender is idle again.
- R4: The request rises only while the synchronized acknowledge is low, and falls only after the synchronized acknowledge has been seen high. `tx_ready` returns to 1 only after the synchronized acknowledge has been seen low again. As a result, `tx_ready` stays low for at least four sending clocks per word, and the word has already been delivered when `tx_ready` returns.
- R5: For each accepted word, `rx_valid` is high for exactly one receiving clock, and `rx_data` equals the accepted word in that cycle.
- R6: `rx_data` holds its value between `rx_valid` pulses.
- R7: Every accepted word is delivered exactly once, unmodified and in order. This holds whether the receiving clock is slower or faster than the sending clock.
- R8: The receiver keeps its acknowledge high until the synchronized request has been seen low, and it raises the acknowledge again only for a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sending domain clock |
| tx_rst | input | 1 | Sending domain reset, active high |
| tx_valid | input | 1 | Word offered on tx_data |
| tx_data | input | DATA_W | Word to transfer |
| tx_ready | output | 1 | Sender idle and able to take a word |
| rx_clk | input | 1 | Receiving domain clock |
| rx_rst | input | 1 | Receiving domain reset, active high |
| rx_valid | output | 1 | One-cycle pulse marking a delivered word |
| rx_data | output | DATA_W | Last delivered word, held between pulses |

## Verification
The transfer is run with the receiving clock slower than the sending clock, much faster than it, and at an unrelated near-equal period. This separates logic that only works when one side gets extra samples from logic that is truly interlocked. Words of all zeros, all ones and alternating bits show whether any bit is dropped or mixed with a neighbour. Streams of random words, sent with and without idle gaps, check ordering and duplication. Junk words held on the input while `tx_ready` is low show whether the input is sampled outside the handshake. Checking, each time `tx_ready` returns, that the word has already arrived distinguishes a real wait on the acknowledge from a shortcut that only holds the request for a while.

// File: rtl/hs_sync_pkg.sv
package hs_sync_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_REQ  = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_t;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_ACK  = 1'b1
  } rx_state_t;

endpackage

// File: rtl/hs_rst_release.sv
module hs_rst_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] chain_q;

  // Assert immediately, release after STAGES local clock edges.
  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain_q[STAGES-1];
endmodule

// File: rtl/hs_bit_sync.sv
module hs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_tx_ctrl.sv
module hs_tx_ctrl
  import hs_sync_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              req,
  input  logic              ack_s,
  output logic [DATA_W-1:0] hold
);
  tx_state_t         state_q, state_d;
  logic              ready_q, req_q;
  logic [DATA_W-1:0] hold_q;
  logic              take;

  assign take = (state_q == TX_IDLE) && ready_q && in_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TX_IDLE: if (take)   state_d = TX_REQ;
      TX_REQ:  if (ack_s)  state_d = TX_WAIT;
      TX_WAIT: if (!ack_s) state_d = TX_IDLE;
      default:             state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= TX_IDLE;
      ready_q <= 1'b0;
      req_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == TX_IDLE);
      req_q   <= (state_d == TX_REQ);
      if (take) hold_q <= in_data;
    end
  end

  assign in_ready = ready_q;
  assign req      = req_q;
  assign hold     = hold_q;

  // R3: bundle frozen while an exchange is in flight
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q != TX_IDLE && $past(state_q) != TX_IDLE) |-> $stable(hold_q));
  // R4: request rises only while acknowledge is seen low
  p_req_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(!ack_s));
  // R4: request falls only after acknowledge was seen high
  p_req_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(req_q) |-> $past(ack_s));
  // R2: ready is never offered while a request is outstanding
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> !req_q);
endmodule

// File: rtl/hs_rx_ctrl.sv
module hs_rx_ctrl
  import hs_sync_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s,
  input  logic [DATA_W-1:0] hold,
  output logic              ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  rx_state_t         state_q, state_d;
  logic              ack_q, vld_q;
  logic [DATA_W-1:0] data_q;
  logic              grab;

  assign grab = (state_q == RX_IDLE) && req_s;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RX_IDLE: if (req_s)  state_d = RX_ACK;
      RX_ACK:  if (!req_s) state_d = RX_IDLE;
      default:             state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= RX_IDLE;
      ack_q   <= 1'b0;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d == RX_ACK);
      vld_q   <= grab;
      if (grab) data_q <= hold;
    end
  end

  assign ack       = ack_q;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  // R5: one-cycle pulse per word
  p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);
  // R6: output word held between pulses
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> $stable(data_q));
  // R8: acknowledge drops only after request seen low
  p_ack_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> $past(!req_s));
  // R8: acknowledge rises only for a seen request
  p_ack_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(req_s));
endmodule

// File: rtl/hs_bundle_xfer.sv
module hs_bundle_xfer #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              tx_clk,
  input  logic              tx_rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_clk,
  input  logic              rx_rst,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  logic              tx_rst_s, rx_rst_s;
  logic              req, req_s, ack, ack_s;
  logic [DATA_W-1:0] hold;

  hs_rst_release #(.STAGES(RST_STAGES)) u_tx_rst (
    .clk(tx_clk), .rst_in(tx_rst), .rst_out(tx_rst_s));
  hs_rst_release #(.STAGES(RST_STAGES)) u_rx_rst (
    .clk(rx_clk), .rst_in(rx_rst), .rst_out(rx_rst_s));

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rx_clk), .rst(rx_rst_s), .d(req), .q(req_s));
  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(tx_clk), .rst(tx_rst_s), .d(ack), .q(ack_s));

  hs_tx_ctrl #(.DATA_W(DATA_W)) u_tx (
    .clk(tx_clk), .rst(tx_rst_s), .in_valid(tx_valid), .in_data(tx_data),
    .in_ready(tx_ready), .req(req), .ack_s(ack_s), .hold(hold));

  hs_rx_ctrl #(.DATA_W(DATA_W)) u_rx (
    .clk(rx_clk), .rst(rx_rst_s), .req_s(req_s), .hold(hold),
    .ack(ack), .out_valid(rx_valid), .out_data(rx_data));
endmodule

// File: tb/hs_bundle_xfer_tb_top.sv
`timescale 1ns/1ps
module hs_bundle_xfer_tb_top;
  localparam int W = 32;
  localparam int SYNC = 2;

  logic tx_clk = 1'b0, rx_clk = 1'b0;
  realtime rx_half = 3.7;
  logic tx_rst, rx_rst, tx_valid, tx_ready, rx_valid;
  logic [W-1:0] tx_data, rx_data;

  always #2.5 tx_clk = ~tx_clk;
  always #(rx_half) rx_clk = ~rx_clk;

  hs_bundle_xfer #(.DATA_W(W), .SYNC_STAGES(SYNC)) dut_i (
    .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_clk(rx_clk), .rx_rst(rx_rst),
    .rx_valid(rx_valid), .rx_data(rx_data));

  int checks = 0, errors = 0, sent = 0, got = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_data = '0;
  bit prev_v = 1'b0, stab_ok = 1'b1, finished = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int min_busy_cycles();
    return 2 * SYNC;  // rise and fall of the acknowledge each cross the chain
  endfunction

  function automatic logic [W-1:0] junk_of(input logic [W-1:0] w);
    return ~w ^ 32'h5A5A_0001;
  endfunction

  // Receive-side monitor: R5, R6, R7
  always @(negedge rx_clk) begin
    if (rx_valid) begin
      check(!prev_v, "R5 pulse length", {31'd0, prev_v}, '0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 extra word", rx_data, '0);
      end else begin
        check(rx_data === exp_q[0], "R5 R7 word", rx_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
      check(stab_ok, "R6 hold between pulses", rx_data, last_data);
      stab_ok = 1'b1;
      last_data = rx_data;
      got++;
    end else if (!rx_rst && rx_data !== last_data) begin
      stab_ok = 1'b0;
    end
    prev_v = rx_valid;
  end

  task automatic send(input logic [W-1:0] w, input bit junk);
    int busy;
    @(negedge tx_clk);
    while (!tx_ready) @(negedge tx_clk);
    tx_valid = 1'b1;
    tx_data  = w;
    @(posedge tx_clk);
    exp_q.push_back(w);
    sent++;
    @(negedge tx_clk);
    busy = 1;
    if (junk) begin
      tx_data = junk_of(w);
      check(tx_ready == 1'b0, "R2 busy after take", {31'd0, tx_ready}, '0);
    end else begin
      tx_valid = 1'b0;
    end
    while (!tx_ready) begin
      @(negedge tx_clk);
      busy++;
    end
    tx_valid = 1'b0;
    check(busy >= min_busy_cycles(), "R4 ready low span", busy, min_busy_cycles());
    check(got == sent, "R4 delivered before ready", got, sent);
  endtask

  task automatic drain();
    int t = 0;
    while (got != sent && t < 2000) begin
      @(negedge tx_clk);
      t++;
    end
    repeat (10) @(negedge rx_clk);
    check(got == sent && exp_q.size() == 0, "R7 all delivered", got, sent);
    check(rx_data === last_data, "R6 idle hold", rx_data, last_data);
  endtask

  initial begin
    realtime ratios [3] = '{7.0, 1.3, 2.7};
    void'($urandom(32'd2024));
    tx_rst = 1'b1; rx_rst = 1'b1; tx_valid = 1'b0; tx_data = '0;
    repeat (4) @(negedge tx_clk);
    check(tx_ready == 1'b0, "R1 ready in reset", {31'd0, tx_ready}, '0);
    check(rx_valid == 1'b0, "R1 valid in reset", {31'd0, rx_valid}, '0);
    check(rx_data == '0, "R1 data in reset", rx_data, '0);
    tx_valid = 1'b1; tx_data = 32'hDEAD_BEEF;  // offered during reset: ignored
    @(negedge rx_clk); rx_rst = 1'b0;
    @(negedge tx_clk); tx_rst = 1'b0; tx_valid = 1'b0;
    repeat (6) @(negedge tx_clk);
    check(tx_ready == 1'b1, "R1 ready after release", {31'd0, tx_ready}, 1);
    foreach (ratios[i]) begin
      rx_half = ratios[i];
      repeat (4) @(negedge tx_clk);
      send('0, 1'b0);
      send('1, 1'b1);
      send(32'hAAAA_5555, 1'b0);
      send(32'h5555_AAAA, 1'b1);
      for (int n = 0; n < 40; n++) begin
        send($urandom, ($urandom_range(0, 3) == 0));
        repeat ($urandom_range(0, 3)) @(negedge tx_clk);
      end
      drain();
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired sent=%0d got=%0d", sent, got);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule